// File: doc/BRIEF.md
# Embedded-Clock 10-Bit Serializer Framer

This block takes a 10-bit parallel word once per parallel-clock period and sends it out one bit per bit-clock cycle inside a 12-bit frame. Each frame opens with a constant 1 and closes with a constant 0, so a receiver always sees at least one edge per frame and can recover the clock from it. The bit clock `clk` runs at twelve times the parallel rate. The parallel clock `par_clk` is sampled as an ordinary synchronous input. A select input chooses which of its edges latches the word.

Two sync-request inputs replace data with a training frame of six 1s followed by six 0s. An output enable and an active-low powerdown control whether the line is driven. `drv_en` stands in for the high-impedance state of an analog driver. Timing-reference lock is modelled as a ready flag. It sets after a parameterizable number of parallel-clock rising edges following reset or powerdown. Every control decision is taken at a frame boundary, so a frame is never cut short.

Top module: `ser12_framer`

## Requirements
- R1: A driven data frame is 12 bits, one per `clk` cycle, sent LSB first as {stop, word[9:0], start}. The start bit comes first, then word bit 0 up to bit 9, then the stop bit.
- R2: In every driven frame the first bit is 1 and the last bit is 0, including for the all-zero and all-ones words.
- R3: When `sync_a` or `sync_b` is high at a frame boundary, the frame sent is the sync frame. Its bit pattern in send order is six 1s then six 0s (12'h03F LSB first).
- R4: The first frame that starts at a boundary where both sync inputs are low carries data again.
- R5: With `edge_sel` high the word is latched on a rising edge of `par_clk`. With `edge_sel` low it is latched on a falling edge.
- R6: When `out_en` is low at a boundary, that frame has `drv_en` low and `ser_out` low. When `out_en` returns high, data resumes at the next boundary with the latched word and no new lock period.
- R7: While `pwr_n` is low, `drv_en` is low, the ready flag and latched word are cleared, and the frame timer waits at a boundary. After `pwr_n` rises, the block repeats the full lock sequence of R8.
- R8: After reset or powerdown exit, the first frame starts on the first active `clk` edge. The ready flag sets on the LOCK_CYCLES-th rising edge of `par_clk`. Frames that start before ready have `drv_en` low. Words offered before ready are discarded, so the first driven frame carries the zero word.
- R9: Changes to `out_en` or the sync inputs in mid-frame do not alter the frame in progress. `drv_en` stays constant over the whole frame.
- R10: During reset `ser_out` and `drv_en` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, twelve times the parallel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_clk | input | 1 | Parallel clock, sampled on `clk` |
| edge_sel | input | 1 | 1: latch on rising edge of `par_clk`, 0: latch on falling edge |
| din | input | PAY_W | Parallel payload word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| out_en | input | 1 | Output enable; low forces high impedance |
| pwr_n | input | 1 | Active-low powerdown |
| ser_out | output | 1 | Serial bit stream |
| drv_en | output | 1 | High when the line is actively driven |

## Verification
A control input changed before a boundary edge governs the frame that begins at that edge. A new payload word shows up one frame later, because the word latched at a boundary's rising edge is stored alongside, not into, the frame loaded at that edge. The bench therefore changes inputs only on the falling clock edge just ahead of a boundary, and it discards one whole frame before comparing a payload. It compares control effects (sync exit, enable return) on the very next frame. After reset or powerdown, the first driven frame is due at the fifth boundary, since four `par_clk` rises are needed for lock. The bench counts those frames itself from its own boundary phase counter and samples each bit at the falling edge inside its slot.

// File: rtl/ser12_pkg.sv
package ser12_pkg;

    localparam int unsigned DEF_PAY_W       = 10;
    localparam int unsigned DEF_LOCK_CYCLES = 4;

    typedef enum logic [1:0] {
        KIND_QUIET,
        KIND_SYNC,
        KIND_DATA
    } frame_kind_t;

endpackage

// File: rtl/ser12_frame_timer.sv
module ser12_frame_timer #(
    parameter int unsigned FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_bit_o,
    output logic boundary_o
);
    localparam int unsigned     CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run_i) begin
            t_d.cnt = LAST;
        end else if (t_q.cnt == LAST) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.cnt <= LAST;
        else        t_q <= t_d;
    end

    assign last_bit_o = (t_q.cnt == LAST);
    assign boundary_o = last_bit_o & run_i;

    // R1: bit position never leaves the frame
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LAST);

    // R1: a running frame wraps to bit 0 after its last bit
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> (t_q.cnt == '0));

endmodule

// File: rtl/ser12_word_capture.sv
module ser12_word_capture #(
    parameter int unsigned PAY_W       = 10,
    parameter int unsigned LOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             par_clk_i,
    input  logic             edge_sel_i,
    input  logic [PAY_W-1:0] din_i,
    output logic             ready_o,
    output logic [PAY_W-1:0] hold_o
);
    localparam int unsigned      LOCK_W    = $clog2(LOCK_CYCLES + 1);
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

    typedef struct packed {
        logic              pclk;
        logic [LOCK_W-1:0] lock_cnt;
        logic              ready;
        logic [PAY_W-1:0]  hold;
    } cap_t;

    cap_t c_d, c_q;
    logic rise, fall, grab;

    always_comb begin
        rise = par_clk_i & ~c_q.pclk;
        fall = ~par_clk_i & c_q.pclk;
        grab = edge_sel_i ? rise : fall;

        c_d      = c_q;
        c_d.pclk = par_clk_i;
        if (!c_q.ready && rise) begin
            if (c_q.lock_cnt == LOCK_LAST) c_d.ready = 1'b1;
            else                           c_d.lock_cnt = c_q.lock_cnt + LOCK_W'(1);
        end
        if (c_q.ready && grab) begin
            c_d.hold = din_i;
        end
        if (!run_i) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ready_o = c_q.ready;
    assign hold_o  = c_q.hold;

    // R8: once ready, the flag only drops through powerdown
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && c_q.ready) |=> c_q.ready);

    // R8: words offered before ready are discarded
    a_r8_pre_ready_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !c_q.ready) |=> $stable(c_q.hold));

    // R7: powerdown clears lock state
    a_r7_pd_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!c_q.ready && c_q.hold == '0));

endmodule

// File: rtl/ser12_frame_shifter.sv
module ser12_frame_shifter
    import ser12_pkg::*;
#(
    parameter int unsigned PAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             boundary_i,
    input  logic             last_bit_i,
    input  logic             ready_i,
    input  logic             oe_i,
    input  logic             sync_req_i,
    input  logic [PAY_W-1:0] hold_i,
    output logic             ser_o,
    output logic             drv_o
);
    localparam int unsigned FRAME_W = PAY_W + 2;
    localparam int unsigned HALF_W  = FRAME_W / 2;
    localparam logic [FRAME_W-1:0] SYNC_PAT =
        {{(FRAME_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic               drv;
    } shf_t;

    shf_t        s_d, s_q;
    frame_kind_t kind;

    always_comb begin
        kind = KIND_QUIET;
        if (ready_i && oe_i) begin
            kind = sync_req_i ? KIND_SYNC : KIND_DATA;
        end

        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (boundary_i) begin
            unique case (kind)
                KIND_SYNC: begin
                    s_d.sreg = SYNC_PAT;
                    s_d.drv  = 1'b1;
                end
                KIND_DATA: begin
                    s_d.sreg = {1'b0, hold_i, 1'b1};
                    s_d.drv  = 1'b1;
                end
                default: begin
                    s_d.sreg = '0;
                    s_d.drv  = 1'b0;
                end
            endcase
        end else begin
            s_d.sreg = s_q.sreg >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser_o = s_q.sreg[0];
    assign drv_o = s_q.drv;

    // R2: a driven frame opens with a 1
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i |=> (!s_q.drv || s_q.sreg[0]));

    // R2: a driven frame closes with a 0
    a_r2_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit_i && s_q.drv) |-> !s_q.sreg[0]);

    // R9: drive state only changes on a boundary or powerdown
    a_r9_drv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !boundary_i) |=> $stable(s_q.drv));

    // R6: output enable low at a boundary gives an undriven frame
    a_r6_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !oe_i) |=> !s_q.drv);

    // R7: powerdown releases the line
    a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!s_q.drv && !s_q.sreg[0]));

    // R8: never driven without ready
    a_r8_no_drive_unready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> !s_q.drv);

endmodule

// File: rtl/ser12_framer.sv
module ser12_framer
    import ser12_pkg::*;
#(
    parameter int unsigned PAY_W       = DEF_PAY_W,
    parameter int unsigned LOCK_CYCLES = DEF_LOCK_CYCLES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_clk,
    input  logic             edge_sel,
    input  logic [PAY_W-1:0] din,
    input  logic             sync_a,
    input  logic             sync_b,
    input  logic             out_en,
    input  logic             pwr_n,
    output logic             ser_out,
    output logic             drv_en
);
    localparam int unsigned FRAME_W = PAY_W + 2;

    logic             last_bit, boundary, ready;
    logic [PAY_W-1:0] hold;
    logic             sync_req;

    assign sync_req = sync_a | sync_b;

    ser12_frame_timer #(
        .FRAME_W (FRAME_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (pwr_n),
        .last_bit_o (last_bit),
        .boundary_o (boundary)
    );

    ser12_word_capture #(
        .PAY_W       (PAY_W),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (pwr_n),
        .par_clk_i  (par_clk),
        .edge_sel_i (edge_sel),
        .din_i      (din),
        .ready_o    (ready),
        .hold_o     (hold)
    );

    ser12_frame_shifter #(
        .PAY_W (PAY_W)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (pwr_n),
        .boundary_i (boundary),
        .last_bit_i (last_bit),
        .ready_i    (ready),
        .oe_i       (out_en),
        .sync_req_i (sync_req),
        .hold_i     (hold),
        .ser_o      (ser_out),
        .drv_o      (drv_en)
    );

endmodule

// File: tb/tb_ser12_framer.sv
module tb_ser12_framer;
    localparam int PAY_W = 10;
    localparam int FW    = 12;
    localparam int LOCK  = 4;

    typedef struct packed {
        logic [PAY_W-1:0] d;
        logic             s1;
        logic             s2;
        logic             oe;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h000, 1'b0, 1'b0, 1'b1},
        '{10'h3FF, 1'b0, 1'b0, 1'b1},
        '{10'h2A5, 1'b0, 1'b0, 1'b1},
        '{10'h2A5, 1'b1, 1'b0, 1'b1},
        '{10'h155, 1'b0, 1'b1, 1'b1},
        '{10'h155, 1'b1, 1'b1, 1'b1},
        '{10'h0C3, 1'b0, 1'b0, 1'b0},
        '{10'h0C3, 1'b0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             par_clk = 1'b1;
    logic             edge_sel = 1'b1;
    logic [PAY_W-1:0] din = '0;
    logic             sync_a = 1'b0, sync_b = 1'b0;
    logic             out_en = 1'b1, pwr_n = 1'b1;
    logic             ser_out, drv_en;

    logic             alt_mode = 1'b0;
    logic [PAY_W-1:0] din_cfg = '0, alt_a = '0, alt_b = '0;
    int               ph = FW - 1;
    int               n_chk = 0, n_fail = 0;
    bit               done = 1'b0;

    ser12_framer #(.PAY_W(PAY_W), .LOCK_CYCLES(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .par_clk(par_clk), .edge_sel(edge_sel),
        .din(din), .sync_a(sync_a), .sync_b(sync_b), .out_en(out_en),
        .pwr_n(pwr_n), .ser_out(ser_out), .drv_en(drv_en)
    );

    always #4 clk = ~clk;

    // Phase of the most recent edge; waits at the boundary in reset or powerdown (R7, R8)
    always @(posedge clk) begin
        if (!rst_n || !pwr_n) ph <= FW - 1;
        else                  ph <= (ph == FW - 1) ? 0 : ph + 1;
    end

    // Parallel clock high for phases 0..5 of the next edge; payload driver
    always @(negedge clk) begin
        int nph;
        #1;
        nph = (ph == FW - 1) ? 0 : ph + 1;
        par_clk = (nph < FW / 2);
        if (alt_mode) din = (nph >= 3 && nph <= 8) ? alt_b : alt_a;
        else          din = din_cfg;
    end

    function automatic logic [FW-1:0] exp_frame(logic [PAY_W-1:0] d, logic s);
        return s ? 12'h03F : {1'b0, d, 1'b1};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic grab(output logic [FW-1:0] bits, output logic drv, output logic same);
        do @(negedge clk); while (ph != 0);
        bits[0] = ser_out;
        drv     = drv_en;
        same    = 1'b1;
        for (int i = 1; i < FW; i++) begin
            @(negedge clk);
            bits[i] = ser_out;
            if (drv_en !== drv) same = 1'b0;
        end
    endtask

    task automatic lock_sequence(string req, logic [PAY_W-1:0] d);
        logic [FW-1:0] b;
        logic dv, sm;
        for (int f = 0; f < LOCK; f++) begin
            grab(b, dv, sm);
            chk({req, " undriven before ready"}, dv, 0);
        end
        grab(b, dv, sm);
        chk({req, " first frame driven"}, dv, 1);
        chk({req, " early word discarded"}, b, exp_frame('0, 1'b0));
        grab(b, dv, sm);
        chk({req, " R1 payload after lock"}, b, exp_frame(d, 1'b0));
        chk("R9 drive constant in frame", sm, 1);
    endtask

    initial begin
        logic [FW-1:0] b;
        logic dv, sm;

        din_cfg = 10'h2A5;
        repeat (3) @(negedge clk);
        chk("R10 reset ser_out", ser_out, 0);
        chk("R10 reset drv_en", drv_en, 0);
        rst_n = 1'b1;
        lock_sequence("R8", 10'h2A5);

        // Table of vectors: discard one frame, then compare
        foreach (VECS[k]) begin
            din_cfg = VECS[k].d;
            sync_a  = VECS[k].s1;
            sync_b  = VECS[k].s2;
            out_en  = VECS[k].oe;
            grab(b, dv, sm);
            grab(b, dv, sm);
            if (!VECS[k].oe) begin
                chk("R6 disabled frame undriven", dv, 0);
                chk("R6 disabled frame line low", b, 0);
            end else if (VECS[k].s1 | VECS[k].s2) begin
                chk("R3 sync frame driven", dv, 1);
                chk("R3 sync pattern", b, exp_frame(VECS[k].d, 1'b1));
            end else begin
                chk("R1 data frame driven", dv, 1);
                chk("R2 R1 data frame bits", b, exp_frame(VECS[k].d, 1'b0));
            end
        end

        // R4: data on the first frame after both sync inputs drop
        din_cfg = 10'h0F0;
        sync_a  = 1'b1;
        grab(b, dv, sm);
        grab(b, dv, sm);
        chk("R3 sync held", b, exp_frame('0, 1'b1));
        sync_a = 1'b0;
        grab(b, dv, sm);
        chk("R4 data right after sync", b, exp_frame(10'h0F0, 1'b0));

        // R9: out_en dropped mid-frame does not cut the frame
        do @(negedge clk); while (ph != 0);
        b[0] = ser_out;
        sm   = drv_en;
        for (int i = 1; i < FW; i++) begin
            @(negedge clk);
            b[i] = ser_out;
            sm   = sm & drv_en;
            if (i == 5) out_en = 1'b0;
        end
        chk("R9 frame completes after mid-frame disable", b, exp_frame(10'h0F0, 1'b0));
        chk("R9 drive held to frame end", sm, 1);
        grab(b, dv, sm);
        chk("R9 disable effective at next boundary", dv, 0);
        out_en = 1'b1;
        grab(b, dv, sm);
        chk("R6 resume without relock", dv, 1);
        chk("R6 resume with held word", b, exp_frame(10'h0F0, 1'b0));

        // R5: capture edge selection
        alt_a    = 10'h111;
        alt_b    = 10'h2EE;
        alt_mode = 1'b1;
        edge_sel = 1'b1;
        grab(b, dv, sm);
        grab(b, dv, sm);
        chk("R5 rising edge capture", b, exp_frame(10'h111, 1'b0));
        edge_sel = 1'b0;
        grab(b, dv, sm);
        grab(b, dv, sm);
        chk("R5 falling edge capture", b, exp_frame(10'h2EE, 1'b0));
        edge_sel = 1'b1;
        alt_mode = 1'b0;

        // R7: powerdown and re-initialization
        pwr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 powerdown undriven", drv_en, 0);
        chk("R7 powerdown line low", ser_out, 0);
        din_cfg = 10'h3C3;
        repeat (5) @(negedge clk);
        chk("R7 still undriven", drv_en, 0);
        pwr_n = 1'b1;
        lock_sequence("R7", 10'h3C3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule